// File: doc/BRIEF.md
# Two-Wire Tuning Command Receiver

This block is the serial slave front end of a modulator-style device. It watches an I2C-compatible two-wire bus (a clock line and an open-drain data line), brings both lines into the system clock domain, and finds START and STOP conditions. It answers to one of four addresses. The upper five address bits are fixed, and two strap inputs pick the remaining two.

A write carries 16-bit words, sent as a high byte followed by a low byte. The top bit of each high byte is a function flag. When the flag is set the word is a control word; when it is clear the word is a frequency word. The other 15 bits are latched into the register that the flag selects, and that register's update strobe is pulsed. Only the first two words of a transaction are taken. Any byte after the fourth gets no acknowledge. A read returns a single byte that carries three status bits, and the slave releases the data line for the acknowledge slot that follows that byte.

The system clock must run at 16 or more times the SCL rate. The block drives the data line only through an active-high pull-low enable.

Top module: `tuner_i2c_rx`

## Requirements
- R1: The slave answers to address byte {5'b11001, addrSel[1:0], rw}, where rw = 0 means write and rw = 1 means read. On a match it holds sdaOe high through the ninth clock of the address byte. On a mismatch it never asserts sdaOe and leaves both word registers unchanged until the next START.
- R2: In a matched write, each of the first four data bytes is acknowledged: sdaOe is high during that byte's ninth clock.
- R3: Bit 7 of the first byte of a word is the function flag, with 1 meaning control and 0 meaning frequency. The stored 15-bit payload is {firstByte[6:0], secondByte[7:0]}. Data bit order is MSB first.
- R4: A word is written to its register only once both of its bytes have arrived. At that point the matching strobe (freqUpd or ctrlUpd) is high for exactly one system clock, and the register holds its value at all other times.
- R5: When exactly three data bytes arrive, the third byte has no effect and only the first word is applied.
- R6: The fifth and any later data bytes get no acknowledge (sdaOe stays low in their ninth clock) and change neither register.
- R7: In a read, the slave acknowledges the address and then shifts out {5'b00000, status[2:0]} MSB first. During the ninth clock of that byte it leaves SDA released.
- R8: A START or repeated START at any point restarts address matching and throws away a word that has only its first byte.
- R9: sdaOe changes only during the SCL low phase.
- R10: After reset, freqWord and ctrlWord are 0 and sdaOe and both strobes are low. After a STOP, sdaOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as sensed at the pin |
| sdaIn | input | 1 | Bus data line as sensed at the pin |
| sdaOe | output | 1 | When high, the pad pulls the data line low |
| addrSel | input | 2 | Strap bits that pick the device address |
| status | input | 3 | Status bits returned by a read |
| freqWord | output | 15 | Last frequency word payload |
| freqUpd | output | 1 | One-cycle strobe when freqWord is written |
| ctrlWord | output | 15 | Last control word payload |
| ctrlUpd | output | 1 | One-cycle strobe when ctrlWord is written |

## Verification
Each bus edge takes two synchronizer flops, one edge-detect flop and one output register, so sdaOe reacts three system clocks after the SCL fall that triggers it. The bench holds every SCL phase for 16 clocks and reads the acknowledge and read data just before the next SCL rise, which puts those reads well after the change has settled. Word registers change at the SCL fall that ends the second byte of a word. They are compared against the bench model eight clocks after STOP, and strobe pulses are counted on every clock across the whole transaction, so no pulse goes uncounted. A separate monitor flags any change of sdaOe while the SCL pin is high.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftIn;   // sample SDA into the receive shifter
    logic ackOn;     // pull SDA low for an acknowledge slot
    logic relSda;    // release SDA
    logic loadTx;    // load status byte and drive its MSB
    logic shiftTx;   // advance to the next transmit bit
    logic takeHi;    // capture first byte of a word
    logic commit;    // second byte arrived: write the word
    logic dropHi;    // discard a half-received word
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_SKIP
  } ctlState_t;

endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lvl,
  output logic lvlQ
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-1:0], lineIn};
  end

  assign lvl  = chain[STAGES-1];
  assign lvlQ = chain[STAGES];
endmodule

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
  import tuner_i2c_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startDet,
  input  logic   stopDet,
  input  logic   addrHit,
  input  logic   rwBit,
  output dpCmd_t cmd,
  output logic   ctlIdle
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] TX_LAST  = BIT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_BYTES);

  ctlState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] byteCnt;
  logic             rwMode;

  logic inRx, byteEnd, wrAck;

  always_comb begin
    inRx    = (state == ST_ADDR) || (state == ST_WR_BYTE);
    byteEnd = sclFall && inRx && (bitCnt == BIT_LAST);
    wrAck   = byteEnd && (state == ST_WR_BYTE) && (byteCnt < CNT_MAX);

    cmd         = '0;
    cmd.shiftIn = sclRise && inRx && (bitCnt < BIT_LAST);
    cmd.ackOn   = (byteEnd && (state == ST_ADDR) && addrHit) || wrAck;
    cmd.takeHi  = wrAck && !byteCnt[0];
    cmd.commit  = wrAck && byteCnt[0];
    cmd.loadTx  = sclFall && (state == ST_ADDR_ACK) && rwMode;
    cmd.shiftTx = sclFall && (state == ST_RD_BYTE) && (bitCnt != TX_LAST);
    cmd.relSda  = startDet || stopDet
               || (sclFall && (state == ST_ADDR_ACK) && !rwMode)
               || (sclFall && (state == ST_WR_ACK))
               || (sclFall && (state == ST_RD_BYTE) && (bitCnt == TX_LAST));
    cmd.dropHi  = startDet || stopDet;
  end

  assign ctlIdle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      rwMode  <= 1'b0;
    end else if (startDet) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (stopDet) begin
      state   <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (cmd.shiftIn) bitCnt <= bitCnt + 1'b1;
          if (byteEnd) begin
            bitCnt <= '0;
            rwMode <= rwBit;
            state  <= addrHit ? ST_ADDR_ACK : ST_SKIP;
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= rwMode ? ST_RD_BYTE : ST_WR_BYTE;
          end
        end
        ST_WR_BYTE: begin
          if (cmd.shiftIn) bitCnt <= bitCnt + 1'b1;
          if (byteEnd) begin
            bitCnt <= '0;
            if (wrAck) begin
              byteCnt <= byteCnt + 1'b1;
              state   <= ST_WR_ACK;
            end else begin
              state   <= ST_SKIP;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) state <= ST_WR_BYTE;
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == TX_LAST) state <= ST_SKIP;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tuner_i2c_dp.sv
module tuner_i2c_dp
  import tuner_i2c_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          STATUS_W = 3,
  parameter int          SEL_W    = 2,
  parameter logic [4:0]  ADDR_FIX = 5'b11001,
  parameter int          WORD_W   = 2 * BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              sdaBit,
  input  logic [SEL_W-1:0]  addrSel,
  input  logic [STATUS_W-1:0] status,
  output logic              addrHit,
  output logic              rwBit,
  output logic              sdaOe,
  output logic [WORD_W-1:0] freqWord,
  output logic              freqUpd,
  output logic [WORD_W-1:0] ctrlWord,
  output logic              ctrlUpd
);
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] hiByte;
  logic              hiValid;
  logic [WORD_W-1:0] newWord;
  logic [BYTE_W-1:0] statusByte;

  assign addrHit    = (rxShift[BYTE_W-1:1] == {ADDR_FIX, addrSel});
  assign rwBit      = rxShift[0];
  assign newWord    = {hiByte[BYTE_W-2:0], rxShift};
  assign statusByte = {{(BYTE_W-STATUS_W){1'b0}}, status};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (cmd.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaBit};
      if (cmd.loadTx)       txShift <= statusByte;
      else if (cmd.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
    end else if (cmd.relSda) begin
      sdaOe <= 1'b0;
    end else if (cmd.ackOn) begin
      sdaOe <= 1'b1;
    end else if (cmd.loadTx) begin
      sdaOe <= ~statusByte[BYTE_W-1];
    end else if (cmd.shiftTx) begin
      sdaOe <= ~txShift[BYTE_W-2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiByte  <= '0;
      hiValid <= 1'b0;
    end else if (cmd.dropHi) begin
      hiValid <= 1'b0;
    end else if (cmd.takeHi) begin
      hiByte  <= rxShift;
      hiValid <= 1'b1;
    end else if (cmd.commit) begin
      hiValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqWord <= '0;
      ctrlWord <= '0;
      freqUpd  <= 1'b0;
      ctrlUpd  <= 1'b0;
    end else begin
      freqUpd <= 1'b0;
      ctrlUpd <= 1'b0;
      if (cmd.commit && hiValid) begin
        if (hiByte[BYTE_W-1]) begin
          ctrlWord <= newWord;
          ctrlUpd  <= 1'b1;
        end else begin
          freqWord <= newWord;
          freqUpd  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tuner_i2c_rx.sv
module tuner_i2c_rx
  import tuner_i2c_pkg::*;
#(
  parameter int         BYTE_W      = 8,
  parameter int         STATUS_W    = 3,
  parameter int         SEL_W       = 2,
  parameter int         SYNC_STAGES = 2,
  parameter int         MAX_BYTES   = 4,
  parameter logic [4:0] ADDR_FIX    = 5'b11001
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  input  logic [SEL_W-1:0]     addrSel,
  input  logic [STATUS_W-1:0]  status,
  output logic [2*BYTE_W-2:0]  freqWord,
  output logic                 freqUpd,
  output logic [2*BYTE_W-2:0]  ctrlWord,
  output logic                 ctrlUpd
);
  localparam int WORD_W = 2 * BYTE_W - 1;
  localparam int N_LINES = 2;  // index 0: SCL, index 1: SDA

  logic [N_LINES-1:0] rawLine, lvl, lvlQ;
  assign rawLine = {sdaIn, sclIn};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    tuner_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rstN(rstN), .lineIn(rawLine[g]), .lvl(lvl[g]), .lvlQ(lvlQ[g])
    );
  end

  logic sclRise, sclFall, startDet, stopDet, busEvt;
  assign sclRise  =  lvl[0] & ~lvlQ[0];
  assign sclFall  = ~lvl[0] &  lvlQ[0];
  assign startDet =  lvl[0] &  lvlQ[0] &  lvlQ[1] & ~lvl[1];
  assign stopDet  =  lvl[0] &  lvlQ[0] & ~lvlQ[1] &  lvl[1];
  assign busEvt   = startDet | stopDet;

  dpCmd_t cmd;
  logic   addrHit, rwBit, ctlIdle;

  tuner_i2c_ctrl #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .addrHit(addrHit), .rwBit(rwBit),
    .cmd(cmd), .ctlIdle(ctlIdle)
  );

  tuner_i2c_dp #(
    .BYTE_W(BYTE_W), .STATUS_W(STATUS_W), .SEL_W(SEL_W),
    .ADDR_FIX(ADDR_FIX), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaBit(lvl[1]), .addrSel(addrSel),
    .status(status), .addrHit(addrHit), .rwBit(rwBit), .sdaOe(sdaOe),
    .freqWord(freqWord), .freqUpd(freqUpd), .ctrlWord(ctrlWord), .ctrlUpd(ctrlUpd)
  );
endmodule

// File: rtl/tuner_i2c_rx_chk.sv
module tuner_i2c_rx_chk #(
  parameter int WORD_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              sclFall,
  input logic              busEvt,
  input logic              ctlIdle,
  input logic              freqUpd,
  input logic              ctrlUpd,
  input logic [WORD_W-1:0] freqWord,
  input logic [WORD_W-1:0] ctrlWord
);
  // R9: the data enable moves only on an SCL fall or a bus condition
  assert_sda_lowphase_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> ($past(sclFall) || $past(busEvt)));

  // R4: strobes last one clock
  assert_freq_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    freqUpd |=> !freqUpd);
  assert_ctrl_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlUpd |=> !ctrlUpd);

  // R4: registers hold unless strobed
  assert_freq_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !freqUpd |-> $stable(freqWord));
  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlUpd |-> $stable(ctrlWord));

  // R3: one word goes to exactly one register
  assert_excl_upd_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(freqUpd && ctrlUpd));

  // R10: bus released whenever the slave is idle
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctlIdle |-> !sdaOe);
endmodule

bind tuner_i2c_rx tuner_i2c_rx_chk #(.WORD_W(2 * BYTE_W - 1)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclFall(sclFall), .busEvt(busEvt),
  .ctlIdle(ctlIdle), .freqUpd(freqUpd), .ctrlUpd(ctrlUpd),
  .freqWord(freqWord), .ctrlWord(ctrlWord)
);

// File: tb/tuner_i2c_rx_bench.sv
`timescale 1ns/1ps
module tuner_i2c_rx_bench;
  localparam int H = 16;  // system clocks per SCL phase

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclPin = 1'b1;
  logic masterSda = 1'b1;
  logic sdaOe;
  logic [1:0] addrSel = 2'b00;
  logic [2:0] status = 3'b000;
  logic [14:0] freqWord, ctrlWord;
  logic freqUpd, ctrlUpd;
  logic sdaLine;

  always #2.5 clk = ~clk;
  assign sdaLine = masterSda & ~sdaOe;

  tuner_i2c_rx u_tuner_i2c_rx (
    .clk(clk), .rstN(rstN), .sclIn(sclPin), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .status(status), .freqWord(freqWord), .freqUpd(freqUpd),
    .ctrlWord(ctrlWord), .ctrlUpd(ctrlUpd)
  );

  int checks = 0;
  int failures = 0;
  int freqCnt = 0, ctrlCnt = 0, expFreqCnt = 0, expCtrlCnt = 0;
  int highChanges = 0;
  bit finished = 0;
  logic [14:0] expFreq = '0, expCtrl = '0;
  logic [7:0] txBytes [6];
  logic prevOe = 1'b0;

  always @(posedge clk) begin
    if (rstN) begin
      if (freqUpd) freqCnt++;
      if (ctrlUpd) ctrlCnt++;
    end
  end

  // R9 monitor: the enable must not move while the SCL pin is high
  always @(negedge clk) begin
    if (rstN && sclPin && (sdaOe !== prevOe)) highChanges++;
    prevOe = sdaOe;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    masterSda = 1'b1; waitClk(H);
    sclPin = 1'b1;    waitClk(H);
    masterSda = 1'b0; waitClk(H);
    sclPin = 1'b0;    waitClk(H/2);
  endtask

  task automatic i2cStop();
    masterSda = 1'b0; waitClk(H);
    sclPin = 1'b1;    waitClk(H);
    masterSda = 1'b1; waitClk(H);
  endtask

  task automatic sendBit(input logic b);
    masterSda = b; waitClk(H);
    sclPin = 1'b1; waitClk(H);
    sclPin = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    masterSda = 1'b1; waitClk(H);
    ack = sdaOe;
    sclPin = 1'b1; waitClk(H);
    ack = ack & sdaOe;
    sclPin = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] d, output logic ninthOe);
    masterSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(H);
      sclPin = 1'b1; waitClk(H/2);
      d[i] = sdaLine; waitClk(H/2);
      sclPin = 1'b0;
    end
    waitClk(H);
    ninthOe = sdaOe;
    sclPin = 1'b1; waitClk(H);
    ninthOe = ninthOe | sdaOe;
    sclPin = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] addr, input int n, output logic [6:0] ackMask);
    logic a;
    ackMask = '0;
    i2cStart();
    sendByte(addr, a); ackMask[0] = a;
    for (int k = 0; k < n; k++) begin
      sendByte(txBytes[k], a); ackMask[k+1] = a;
    end
    i2cStop();
    waitClk(8);
  endtask

  // Bench model of a write transaction
  function automatic logic [6:0] modelWrite(input logic [7:0] addr, input int n);
    logic [6:0] m = '0;
    int taken;
    if (addr[7:1] != {5'b11001, addrSel} || addr[0]) return m;
    m[0] = 1'b1;
    taken = (n > 4) ? 4 : n;
    for (int k = 0; k < taken; k++) m[k+1] = 1'b1;
    for (int p = 0; p < 2; p++) begin
      if (2*p + 1 < taken) begin
        if (txBytes[2*p][7]) begin
          expCtrl = {txBytes[2*p][6:0], txBytes[2*p+1]}; expCtrlCnt++;
        end else begin
          expFreq = {txBytes[2*p][6:0], txBytes[2*p+1]}; expFreqCnt++;
        end
      end
    end
    return m;
  endfunction

  task automatic checkRegs(input string req);
    chk(freqWord == expFreq, {req, " freqWord"}, freqWord, expFreq);
    chk(ctrlWord == expCtrl, {req, " ctrlWord"}, ctrlWord, expCtrl);
    chk(freqCnt == expFreqCnt, {req, " freqUpd count"}, freqCnt, expFreqCnt);
    chk(ctrlCnt == expCtrlCnt, {req, " ctrlUpd count"}, ctrlCnt, expCtrlCnt);
    chk(sdaOe == 1'b0, {req, " R10 sdaOe after stop"}, sdaOe, 0);
  endtask

  task automatic runWrite(input logic [7:0] addr, input int n, input string req);
    logic [6:0] got, exp;
    exp = modelWrite(addr, n);
    doWrite(addr, n, got);
    chk(got == exp, {req, " ack pattern"}, got, exp);
    checkRegs(req);
  endtask

  initial begin
    #(5 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic ninth, a;
    logic [6:0] got;
    void'($urandom(32'h5eed1234));
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R10: reset state
    chk(freqWord == 0, "R10 reset freqWord", freqWord, 0);
    chk(ctrlWord == 0, "R10 reset ctrlWord", ctrlWord, 0);
    chk(sdaOe == 0 && !freqUpd && !ctrlUpd, "R10 reset outputs", sdaOe, 0);

    // R3: frequency word then control word, two-word transaction
    addrSel = 2'b10;
    txBytes[0] = 8'h12; txBytes[1] = 8'h34; txBytes[2] = 8'hC5; txBytes[3] = 8'h6A;
    runWrite(8'hCC, 4, "R3 R2 two words");

    // R1: each address select value
    for (int s = 0; s < 4; s++) begin
      addrSel = 2'(s);
      txBytes[0] = 8'(8'h80 | s); txBytes[1] = 8'(8'h10 + s);
      runWrite({5'b11001, 2'(s), 1'b0}, 2, "R1 address select");
    end

    // R1: mismatch, no ack, no change
    addrSel = 2'b00;
    txBytes[0] = 8'h7F; txBytes[1] = 8'hFF;
    runWrite(8'hCE, 2, "R1 mismatch");

    // R5: exactly three bytes
    txBytes[0] = 8'h81; txBytes[1] = 8'h23; txBytes[2] = 8'h05;
    runWrite(8'hC8, 3, "R5 three bytes");

    // R6: six bytes
    txBytes[0] = 8'h0A; txBytes[1] = 8'hBC; txBytes[2] = 8'hFE; txBytes[3] = 8'hDC;
    txBytes[4] = 8'h00; txBytes[5] = 8'h11;
    runWrite(8'hC8, 6, "R6 extra bytes");

    // R8: repeated START after half a word
    i2cStart();
    sendByte(8'hC8, a);
    sendByte(8'h55, a);
    i2cStart();
    sendByte(8'hC8, a);
    sendByte(8'h9B, a);
    chk(a == 1'b1, "R8 ack after restart", a, 1);
    sendByte(8'h42, a);
    i2cStop();
    waitClk(8);
    expCtrl = 15'h1B42; expCtrlCnt++;
    checkRegs("R8 restart");

    // R7: read status
    for (int v = 0; v < 3; v++) begin
      status = (v == 0) ? 3'b101 : (v == 1) ? 3'b010 : 3'b111;
      addrSel = 2'(v + 1);
      i2cStart();
      sendByte({5'b11001, addrSel, 1'b1}, a);
      chk(a == 1'b1, "R7 read address ack", a, 1);
      readByte(rd, ninth);
      chk(rd == {5'b0, status}, "R7 status byte", rd, {5'b0, status});
      chk(ninth == 1'b0, "R7 no ack after status", ninth, 0);
      i2cStop();
      waitClk(8);
      chk(sdaOe == 1'b0, "R10 released after read", sdaOe, 0);
    end

    // Random traffic
    for (int t = 0; t < 24; t++) begin
      int n;
      logic [7:0] addr;
      addrSel = 2'($urandom_range(0, 3));
      n = $urandom_range(0, 6);
      for (int k = 0; k < 6; k++) txBytes[k] = 8'($urandom);
      if ($urandom_range(0, 3) == 0) addr = {8'($urandom)} & 8'hFE;
      else addr = {5'b11001, addrSel, 1'b0};
      runWrite(addr, n, "R2 R3 R4 random");
    end

    chk(highChanges == 0, "R9 sdaOe moved during SCL high", highChanges, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule